// File: doc/BRIEF.md
# Serial NOR Flash Command Front End

This block is the register-level front end of a serial NOR flash controller. A small word-addressed array inside the block stands in for the flash, so the command rules can be used and checked without a serial pin interface. Software drives a 32-bit register port. Through it, software issues memory-operation commands: arm writes, erase one sector, lock every sector, or unlock every sector. The same port lets software read back a status word and a flag word. A separate 32-bit data port reads array words and programs them.

Every erase, program or lock change must be armed by a separate write-enable command, and any of these commands disarms it again. Programming follows NOR rules: a write can only clear bits, and bytes that software does not mean to change are sent as 0xFF. An erase returns a whole sector to all ones, and a lock or unlock changes the protection state. Both erase and lock changes hold the controller busy for a parameterised number of cycles, and software polls the ready flag to see when they finish. Attempts on protected sectors and erases of sectors that do not exist raise sticky error flags. Software clears these flags by writing zeros to the flag word.

Register byte offsets: status at 0x00, memory operation at 0x0C, flag word at 0x1C. Other offsets read as zero and ignore writes. The data port uses valid/ready. A request is held with `dat_valid` until a cycle in which `dat_ready` is high. `dat_ready` is low only while an erase or lock change is in progress. A read response comes exactly one cycle after the request is accepted, and it cannot be back-pressured. SECTORS and WORDS_PER_SECTOR are powers of two, and SECTORS is at least 2.

Top module: `nor_cmd_front`

## Requirements
- R1: After reset, the status word reads 0x00000000, the flag word reads 0x00000080, and every array word reads 0xFFFFFFFF.
- R2: Writing exactly 0x00000004 to the memory-operation register sets the write-enable latch, which reads back in status bit 1.
- R3: An erase (0x02 in bits 7:0, sector index in bits 15:8, bits 31:16 zero), lock (0xF03), unlock (0x003) or data-port program issued while the latch is clear has no effect on the array, the busy bit (status bit 0), the protection field or the flags.
- R4: The latch clears on the cycle after an erase, lock, unlock or program command is accepted with the latch set.
- R5: A program of word W at address A, with the latch set and the array unlocked, leaves the old word ANDed with W at A and changes no other word.
- R6: A valid erase holds status bit 0 high and flag bit 7 (ready) low for exactly ERASE_CYCLES cycles. After that, every word of the addressed sector reads 0xFFFFFFFF and words in other sectors are unchanged.
- R7: After lock or unlock, the busy bit is high for LOCK_CYCLES cycles. The 5-bit protection field at status bits 6:2 then reads 0x17 after a lock and 0x00 after an unlock.
- R8: While locked, an armed program leaves the array unchanged and sets flag bits 1 (protection error) and 4 (program error). An armed erase of an in-range sector starts no busy period and sets flag bits 1 and 5 (erase error).
- R9: An armed erase whose sector index is SECTORS or larger sets flag bit 5 only, starts no busy period and changes no word.
- R10: A write to the flag word clears each sticky bit (1, 4, 5) whose written bit is 0 and keeps the others. Bits 2 and 6 always read 0.
- R11: `dat_ready` is low while busy. A read accepted at a clock edge gives `dat_rvalid` high with the word in `dat_rdata` after the next edge.
- R12: Memory-operation writes, write-enable included, are ignored while the busy bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| dat_valid | input | 1 | Data-port request valid |
| dat_ready | output | 1 | Data-port request accepted when high with valid |
| dat_we | input | 1 | Request is a program (1) or a read (0) |
| dat_addr | input | AW | Word address into the array |
| dat_wdata | input | 32 | Program word |
| dat_rvalid | output | 1 | Read response valid |
| dat_rdata | output | 32 | Read response word |

## Verification
Programming is tried with random addresses and random words, both dense words and single-zero words. Some programs are sent without the arming command, so a program that lands is told apart from one that must be dropped. Erase is checked by counting busy cycles exactly and then reading back the whole array. This shows that only the addressed sector returns to ones. Locked program and erase attempts, an out-of-range sector index, partial and full flag clears, and command writes made during busy each produce a distinct flag word or status word. Each of these cases is separated from the plain success path.

// File: rtl/nor_pkg.sv
package nor_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_STATUS = 5'h00;
  localparam logic [REG_AW-1:0] OFS_MEMOP  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_FLAGS  = 5'h1C;

  localparam logic [31:0] CMD_ARM    = 32'h0000_0004;
  localparam logic [31:0] CMD_LOCK   = 32'h0000_0F03;
  localparam logic [31:0] CMD_UNLOCK = 32'h0000_0003;
  localparam logic [7:0]  CMD_ERASE  = 8'h02;

  localparam int FB_PROT  = 1;
  localparam int FB_PGERR = 4;
  localparam int FB_ERERR = 5;
  localparam int FB_READY = 7;

  localparam logic [4:0] PROT_ALL  = 5'h17;
  localparam logic [4:0] PROT_NONE = 5'h00;

  typedef enum logic [1:0] {
    OP_ERASE  = 2'd0,
    OP_LOCK   = 2'd1,
    OP_UNLOCK = 2'd2
  } op_kind_e;
endpackage

// File: rtl/nor_op_decode.sv
module nor_op_decode
  import nor_pkg::*;
(
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              memop_wr,
  output logic              flags_wr,
  output logic              is_arm,
  output logic              is_erase,
  output logic              is_lock,
  output logic              is_unlock,
  output logic [7:0]        erase_idx
);
  always_comb begin
    memop_wr  = reg_we && (reg_addr == OFS_MEMOP);
    flags_wr  = reg_we && (reg_addr == OFS_FLAGS);
    is_arm    = (reg_wdata == CMD_ARM);
    is_lock   = (reg_wdata == CMD_LOCK);
    is_unlock = (reg_wdata == CMD_UNLOCK);
    is_erase  = (reg_wdata[7:0] == CMD_ERASE) && (reg_wdata[31:16] == 16'h0);
    erase_idx = reg_wdata[15:8];
  end
endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start && !busy) cnt_q <= len;
    else if (busy)          cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
  parameter int WORDS = 32,
  parameter int WPS   = 8,
  parameter int SW    = 2,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          erase_en,
  input  logic [SW-1:0] erase_sec,
  output logic          rvalid,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      if (prog_en) mem[addr] <= mem[addr] & wdata;
      if (erase_en)
        for (int i = 0; i < WORDS; i++)
          if ((i / WPS) == int'(erase_sec)) mem[i] <= '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/nor_cmd_front.sv
module nor_cmd_front
  import nor_pkg::*;
#(
  parameter int SECTORS          = 4,
  parameter int WORDS_PER_SECTOR = 8,
  parameter int ERASE_CYCLES     = 20,
  parameter int LOCK_CYCLES      = 4,
  localparam int WORDS = SECTORS * WORDS_PER_SECTOR,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic              dat_we,
  input  logic [AW-1:0]     dat_addr,
  input  logic [31:0]       dat_wdata,
  output logic              dat_rvalid,
  output logic [31:0]       dat_rdata
);
  localparam int SW    = $clog2(SECTORS);
  localparam int MAXC  = (ERASE_CYCLES > LOCK_CYCLES) ? ERASE_CYCLES : LOCK_CYCLES;
  localparam int CW    = $clog2(MAXC + 1);

  logic memop_wr, flags_wr, is_arm, is_erase, is_lock, is_unlock;
  logic [7:0] erase_idx;
  logic busy, done, start;
  logic [CW-1:0] tlen;

  logic wel_q, locked_q, perr_q, pgerr_q, ererr_q;
  op_kind_e pend_kind_q;
  logic [SW-1:0] pend_sec_q;

  nor_op_decode u_dec (
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .memop_wr(memop_wr), .flags_wr(flags_wr), .is_arm(is_arm),
    .is_erase(is_erase), .is_lock(is_lock), .is_unlock(is_unlock),
    .erase_idx(erase_idx)
  );

  logic memop_ok, arm_cmd, erase_cmd, lock_cmd, unlock_cmd, prog_fire, rd_fire;
  logic bad_idx, erase_go;

  always_comb begin
    memop_ok   = memop_wr && !busy;
    arm_cmd    = memop_ok && is_arm;
    erase_cmd  = memop_ok && is_erase && wel_q;
    lock_cmd   = memop_ok && is_lock && wel_q;
    unlock_cmd = memop_ok && is_unlock && wel_q;
    dat_ready  = !busy;
    prog_fire  = dat_valid && dat_ready && dat_we && wel_q;
    rd_fire    = dat_valid && dat_ready && !dat_we;
    bad_idx    = (int'(erase_idx) >= SECTORS);
    erase_go   = erase_cmd && !bad_idx && !locked_q;
    start      = erase_go || lock_cmd || unlock_cmd;
    tlen       = erase_go ? CW'(ERASE_CYCLES) : CW'(LOCK_CYCLES);
  end

  nor_busy_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .len(tlen),
    .busy(busy), .done(done)
  );

  nor_word_array #(.WORDS(WORDS), .WPS(WORDS_PER_SECTOR), .SW(SW)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .prog_en(prog_fire && !locked_q), .rd_en(rd_fire),
    .addr(dat_addr), .wdata(dat_wdata),
    .erase_en(done && (pend_kind_q == OP_ERASE)), .erase_sec(pend_sec_q),
    .rvalid(dat_rvalid), .rdata(dat_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q       <= 1'b0;
      locked_q    <= 1'b0;
      pend_kind_q <= OP_ERASE;
      pend_sec_q  <= '0;
    end else begin
      if (arm_cmd) wel_q <= 1'b1;
      else if (erase_cmd || lock_cmd || unlock_cmd || prog_fire) wel_q <= 1'b0;
      if (start) begin
        pend_kind_q <= erase_go ? OP_ERASE : (lock_cmd ? OP_LOCK : OP_UNLOCK);
        pend_sec_q  <= erase_idx[SW-1:0];
      end
      if (done && pend_kind_q == OP_LOCK)   locked_q <= 1'b1;
      if (done && pend_kind_q == OP_UNLOCK) locked_q <= 1'b0;
    end
  end

  // Sticky flags: a set in the same cycle wins over a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q  <= 1'b0;
      pgerr_q <= 1'b0;
      ererr_q <= 1'b0;
    end else begin
      perr_q  <= (flags_wr ? (perr_q  & reg_wdata[FB_PROT])  : perr_q)
               | (prog_fire && locked_q) | (erase_cmd && !bad_idx && locked_q);
      pgerr_q <= (flags_wr ? (pgerr_q & reg_wdata[FB_PGERR]) : pgerr_q)
               | (prog_fire && locked_q);
      ererr_q <= (flags_wr ? (ererr_q & reg_wdata[FB_ERERR]) : ererr_q)
               | (erase_cmd && (bad_idx || locked_q));
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_STATUS: reg_rdata = {25'h0, (locked_q ? PROT_ALL : PROT_NONE), wel_q, busy};
      OFS_FLAGS: begin
        reg_rdata[FB_READY] = !busy;
        reg_rdata[FB_ERERR] = ererr_q;
        reg_rdata[FB_PGERR] = pgerr_q;
        reg_rdata[FB_PROT]  = perr_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R4
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_fire && !arm_cmd) |=> !wel_q);
  // R8
  locked_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_fire && locked_q) |=> (perr_q && pgerr_q));
  // R9
  bad_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_cmd && bad_idx) |=> (!busy && ererr_q));
  // R11
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rvalid |-> $past(dat_valid && dat_ready && !dat_we));
  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && memop_wr && !wel_q) |=> !wel_q);
endmodule

// File: tb/test_nor_cmd_front.sv
module test_nor_cmd_front;
  localparam int SECT = 4, WPS = 8, ERC = 20, LKC = 4, NW = SECT * WPS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = 5'h0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dat_valid = 1'b0, dat_we = 1'b0, dat_ready, dat_rvalid;
  logic [4:0] dat_addr = '0;
  logic [31:0] dat_wdata = '0, dat_rdata;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] exp_mem [NW];

  always #2 clk = ~clk;

  nor_cmd_front #(.SECTORS(SECT), .WORDS_PER_SECTOR(WPS),
                  .ERASE_CYCLES(ERC), .LOCK_CYCLES(LKC)) i_nor_cmd_front (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dat_valid(dat_valid),
    .dat_ready(dat_ready), .dat_we(dat_we), .dat_addr(dat_addr),
    .dat_wdata(dat_wdata), .dat_rvalid(dat_rvalid), .dat_rdata(dat_rdata));

  function automatic logic [31:0] flag_word(bit p, bit pg, bit er, bit bsy);
    return {24'h0, ~bsy, 1'b0, er, pg, 2'b00, p, 1'b0};
  endfunction

  function automatic logic [31:0] stat_word(bit lk, bit wel, bit bsy);
    return {25'h0, (lk ? 5'h17 : 5'h00), wel, bsy};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic dat_write(int a, logic [31:0] w);
    @(negedge clk);
    dat_valid = 1'b1; dat_we = 1'b1; dat_addr = 5'(a); dat_wdata = w;
    while (!dat_ready) @(negedge clk);
    @(negedge clk);
    dat_valid = 1'b0; dat_we = 1'b0;
  endtask

  task automatic dat_read(int a, output logic [31:0] d);
    @(negedge clk);
    dat_valid = 1'b1; dat_we = 1'b0; dat_addr = 5'(a);
    while (!dat_ready) @(negedge clk);
    @(negedge clk);
    dat_valid = 1'b0;
    check("R11 rvalid one cycle after accept", {31'h0, dat_rvalid}, 32'h1);
    d = dat_rdata;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    for (int i = 0; i < NW; i++) begin
      dat_read(i, d);
      check(tag, d, exp_mem[i]);
    end
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] s;
    n = 0;
    reg_read(5'h00, s);
    while (s[0]) begin
      n++;
      @(negedge clk);
      reg_read(5'h00, s);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < NW; i++) exp_mem[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(5'h00, d); check("R1 status", d, stat_word(0, 0, 0));
    reg_read(5'h1C, d); check("R1 flags", d, flag_word(0, 0, 0, 0));
    dat_read(0, d); check("R1 erased word", d, 32'hFFFF_FFFF);
    dat_read(NW - 1, d); check("R1 erased word last", d, 32'hFFFF_FFFF);

    // R3 unarmed program and erase do nothing
    dat_write(5, 32'h0000_0000);
    dat_read(5, d); check("R3 unarmed program", d, 32'hFFFF_FFFF);
    reg_write(5'h0C, 32'h0000_0002);
    reg_read(5'h00, d); check("R3 unarmed erase status", d, stat_word(0, 0, 0));
    reg_write(5'h0C, 32'h0000_0F03);
    repeat (LKC + 2) @(negedge clk);
    reg_read(5'h00, d); check("R3 unarmed lock status", d, stat_word(0, 0, 0));
    reg_read(5'h1C, d); check("R3 unarmed flags", d, flag_word(0, 0, 0, 0));

    // R2 arm, R4 disarm on program
    reg_write(5'h0C, 32'h0000_0004);
    reg_read(5'h00, d); check("R2 latch set", d, stat_word(0, 1, 0));
    dat_write(6, 32'hFFFF_00FF);
    exp_mem[6] = 32'hFFFF_00FF;
    reg_read(5'h00, d); check("R4 latch cleared after program", d, stat_word(0, 0, 0));

    // R5 random programs, some unarmed
    for (int k = 0; k < 80; k++) begin
      int a;
      logic [31:0] w;
      bit arm;
      a = int'($urandom % NW);
      w = ($urandom % 2) ? ($urandom | $urandom | $urandom) : ~(32'h1 << ($urandom % 32));
      arm = ($urandom % 4) != 0;
      if (arm) reg_write(5'h0C, 32'h0000_0004);
      dat_write(a, w);
      if (arm) exp_mem[a] = exp_mem[a] & w;
      dat_read(a, d);
      check(arm ? "R5 program AND" : "R3 unarmed random program", d, exp_mem[a]);
    end
    reg_read(5'h1C, d); check("R5 no flags after programs", d, flag_word(0, 0, 0, 0));
    for (int i = 8; i < 16; i++) if (exp_mem[i] == '1) begin
      reg_write(5'h0C, 32'h0000_0004); dat_write(i, 32'h1234_5678);
      exp_mem[i] = 32'h1234_5678;
    end

    // R6 erase sector 1
    reg_write(5'h0C, 32'h0000_0004);
    reg_write(5'h0C, 32'h0000_0102);
    reg_read(5'h1C, d); check("R6 ready low during erase", d, flag_word(0, 0, 0, 1));
    check("R11 dat_ready low while busy", {31'h0, dat_ready}, 32'h0);
    wait_idle(n);
    check("R6 busy cycle count", 32'(n), 32'(ERC));
    for (int i = 8; i < 16; i++) exp_mem[i] = '1;
    check_all("R6 sector erased others kept");

    // R12 commands ignored while busy
    reg_write(5'h0C, 32'h0000_0004);
    reg_write(5'h0C, 32'h0000_0202);
    reg_write(5'h0C, 32'h0000_0004);
    wait_idle(n);
    reg_read(5'h00, d); check("R12 arm during busy ignored", d, stat_word(0, 0, 0));
    for (int i = 16; i < 24; i++) exp_mem[i] = '1;

    // R7 lock
    reg_write(5'h0C, 32'h0000_0004);
    reg_write(5'h0C, 32'h0000_0F03);
    wait_idle(n);
    check("R7 lock busy cycles", 32'(n), 32'(LKC));
    reg_read(5'h00, d); check("R7 locked field", d, stat_word(1, 0, 0));

    // R8 locked program and erase
    reg_write(5'h0C, 32'h0000_0004);
    dat_write(3, 32'h0000_0000);
    dat_read(3, d); check("R8 locked program unchanged", d, exp_mem[3]);
    reg_read(5'h1C, d); check("R8 program flags", d, flag_word(1, 1, 0, 0));
    reg_write(5'h1C, 32'h0);
    reg_read(5'h1C, d); check("R10 full clear", d, flag_word(0, 0, 0, 0));
    reg_write(5'h0C, 32'h0000_0004);
    reg_write(5'h0C, 32'h0000_0002);
    reg_read(5'h00, d); check("R8 locked erase no busy", d, stat_word(1, 0, 0));
    reg_read(5'h1C, d); check("R8 erase flags", d, flag_word(1, 0, 1, 0));
    reg_write(5'h1C, 32'hFFFF_FFFD);
    reg_read(5'h1C, d); check("R10 partial clear", d, flag_word(0, 0, 1, 0));
    reg_write(5'h1C, 32'h0);

    // R7 unlock
    reg_write(5'h0C, 32'h0000_0004);
    reg_write(5'h0C, 32'h0000_0003);
    wait_idle(n);
    reg_read(5'h00, d); check("R7 unlocked field", d, stat_word(0, 0, 0));

    // R9 out-of-range sector
    reg_write(5'h0C, 32'h0000_0004);
    reg_write(5'h0C, 32'h0000_0402);
    reg_read(5'h00, d); check("R9 no busy", d, stat_word(0, 0, 0));
    reg_read(5'h1C, d); check("R9 erase error only", d, flag_word(0, 0, 1, 0));
    reg_write(5'h1C, 32'h0);
    reg_write(5'h0C, 32'h0000_0004);
    reg_write(5'h0C, 32'h0000_C802);
    reg_read(5'h1C, d); check("R9 large index", d, flag_word(0, 0, 1, 0));
    check_all("R9 array untouched");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule